// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block runs the transmit half of a shared-memory descriptor ring. Host software fills a buffer, writes a four-word descriptor that points at it, hands the descriptor over by setting its ownership bit, and then pulses a demand strobe. The engine can also find the descriptor without any demand, because an idle poll timer makes it look on its own. Once it owns a descriptor, the engine turns the stored negative byte count into a length and reads the buffer word by word. It sends the bytes, low byte first, on a byte-wide valid/ready stream.

When the last byte has gone, the engine waits for a single outcome strobe from a stubbed MAC. It writes that outcome into the descriptor: collision counts go in the status word, and failure flags plus a reflectometry count go in the error word. It then hands ownership back, pulses the interrupt output and moves to the next ring slot, whose descriptor it checks at once. The ring holds a power-of-two number of descriptors, set by a log2 input, and the index wraps to zero.

Descriptor word k sits at `ring_base + 4*index + k`. Word 0 holds the buffer address bits 15:0. Word 1 is the status word. Word 2 holds the count in two's complement. Word 3 is the error word.

The controller moves through these states:

- IDLE waits for a demand or a poll. It goes to FETCH_STAT.
- FETCH_STAT reads the status word. It goes back to IDLE if the engine does not own the descriptor, and to FETCH_ADDR if it does.
- FETCH_ADDR reads the address word and goes to FETCH_CNT.
- FETCH_CNT reads the count word and goes to CLEAR_ERR.
- CLEAR_ERR zeroes the error word. It goes to FETCH_DATA for a valid frame and straight to STORE_ERR for a rejected one.
- FETCH_DATA reads one buffer word and goes to SEND.
- SEND stays in SEND for the high byte. After the high byte it goes back to FETCH_DATA. After the final byte it goes to WAIT_MAC. On a stall timeout it goes to STORE_ERR.
- WAIT_MAC waits for the outcome strobe and goes to STORE_ERR.
- STORE_ERR writes the error word and goes to STORE_STAT.
- STORE_STAT writes the status word back and goes to FETCH_STAT for the next slot.

Top module: `tx_ring_engine`

## Requirements
- R1: Out of reset, `tx_valid`, `tx_irq` and `mem_req` are low and the ring index is 0.
- R2: A descriptor whose status bit 15 (ownership) is clear is left alone. Demand and poll checks of it produce no stream bytes, no interrupt and no change to any of its words.
- R3: With no demand, an idle engine checks the current descriptor once every POLL_CYCLES cycles and processes it if the engine owns it.
- R4: The frame length is the negation of word 2, bits LEN_W-1:0. Exactly that many bytes are streamed from word address `{status[7:0], word0}` upward, low byte of each word first. `tx_last` is high on the final byte only.
- R5: A frame is sent only if status bits 9 (start) and 8 (end) are both set and the length is non-zero. Any other descriptor is released with no bytes sent, with error word 0x8000 (bit 15, buffer error) and with status bit 14 set.
- R6: The MAC outcome is written back as follows. Single collision goes to status bit 12 and multiple collisions to status bit 13. Late collision goes to error bit 12, lost carrier to bit 11 and retry failure to bit 10. The TDR count goes to error bits 9:0. Status bit 14 is set exactly when any of error bits 15, 14, 12, 11 or 10 is set.
- R7: On release, the error word is written before the status word. The written status has bit 15 clear and keeps the descriptor's own bits 11:0.
- R8: If `tx_valid` is held with `tx_ready` low for STALL_LIMIT cycles, the frame is aborted without waiting for the MAC. The error word gets bit 14 (underflow) and the status gets bit 14.
- R9: `tx_irq` is a one-cycle pulse, given exactly once per released descriptor.
- R10: After each release, the index steps by one modulo 2^ring_log2 and that descriptor is checked immediately. Descriptors outside the ring are never touched.
- R11: While `tx_valid` is high and `tx_ready` low, `tx_valid` and `tx_data` stay unchanged, unless the stall abort of R8 fires.
- R12: `mem_req`, `mem_we` and `mem_addr` stay unchanged from the cycle a request is raised until the cycle `mem_ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_base | input | ADDR_W | Word address of descriptor 0 |
| ring_log2 | input | clog2(MAX_LOG2+1) | log2 of the ring length |
| tx_demand | input | 1 | Host strobe asking for an immediate ring check |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Word address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Request completed |
| tx_data | output | 8 | Stream byte |
| tx_valid | output | 1 | Stream byte valid |
| tx_last | output | 1 | Final byte of the frame |
| tx_ready | input | 1 | Sink accepts the byte |
| mac_status_vld | input | 1 | MAC outcome strobe |
| mac_one_coll | input | 1 | Exactly one collision |
| mac_multi_coll | input | 1 | More than one collision |
| mac_late_coll | input | 1 | Late collision |
| mac_lost_carrier | input | 1 | Carrier lost |
| mac_retry_fail | input | 1 | Retries exhausted |
| mac_tdr | input | 10 | Reflectometry count |
| tx_irq | output | 1 | Release pulse |

## Verification
Most internal faults in this engine reach memory within one frame. A wrong ring index shows up as a status write-back to the wrong slot, or as a touched descriptor outside the ring, on the first release after the fault. A wrong byte counter or half-word selector shows at once as a wrong byte, a missing or extra byte, or a misplaced `tx_last` on the stream. A bad flag register appears in the error or status word written back a few cycles after the MAC strobe, together with the interrupt. Stall and poll timer faults show as a premature or missing abort, or as a missing unprompted transfer, within one timer period.

// File: rtl/txr_pkg.sv
package txr_pkg;

    localparam int WORD_W = 16;
    localparam int TDR_W  = 10;
    localparam int HADR_W = 8;

    // descriptor word offsets
    localparam int OFF_LADR = 0;
    localparam int OFF_STAT = 1;
    localparam int OFF_CNT  = 2;
    localparam int OFF_ERR  = 3;

    // status word bits
    localparam int SB_OWN  = 15;
    localparam int SB_ERR  = 14;
    localparam int SB_MORE = 13;
    localparam int SB_ONE  = 12;
    localparam int SB_STP  = 9;
    localparam int SB_ENP  = 8;

    // error word bits
    localparam int EB_BUFF = 15;
    localparam int EB_UFLO = 14;
    localparam int EB_LCOL = 12;
    localparam int EB_LCAR = 11;
    localparam int EB_RTRY = 10;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FETCH_STAT,
        ST_FETCH_ADDR,
        ST_FETCH_CNT,
        ST_CLEAR_ERR,
        ST_FETCH_DATA,
        ST_SEND,
        ST_WAIT_MAC,
        ST_STORE_ERR,
        ST_STORE_STAT
    } txr_state_e;

endpackage

// File: rtl/txr_ring_index.sv
module txr_ring_index #(
    parameter int ADDR_W   = 24,
    parameter int MAX_LOG2 = 7
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          advance,
    input  logic [$clog2(MAX_LOG2+1)-1:0] ring_log2,
    input  logic [ADDR_W-1:0]             ring_base,
    output logic [ADDR_W-1:0]             desc_addr
);
    localparam int LOG_W = $clog2(MAX_LOG2 + 1);

    logic [MAX_LOG2-1:0] idx_q;
    logic [MAX_LOG2-1:0] wrap_mask;
    logic [LOG_W-1:0]    eff_log2;

    always_comb begin
        eff_log2  = (int'(ring_log2) > MAX_LOG2) ? LOG_W'(MAX_LOG2) : ring_log2;
        wrap_mask = (MAX_LOG2'(1) << eff_log2) - MAX_LOG2'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (advance) begin
            idx_q <= (idx_q + MAX_LOG2'(1)) & wrap_mask;
        end
    end

    assign desc_addr = ring_base + (ADDR_W'(idx_q) << 2);

    AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> (idx_q == '0) || (idx_q == $past(idx_q) + MAX_LOG2'(1))); // R10

endmodule

// File: rtl/txr_poll_timer.sv
module txr_poll_timer #(
    parameter int POLL_CYCLES = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic due
);
    localparam int CW = $clog2(POLL_CYCLES + 1);

    logic [CW-1:0] cnt_q;

    assign due = run && (cnt_q == CW'(POLL_CYCLES - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || due) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt_q) < POLL_CYCLES); // R3

endmodule

// File: rtl/txr_stall_watch.sv
module txr_stall_watch #(
    parameter int STALL_LIMIT = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stalled,
    output logic hit
);
    localparam int CW = $clog2(STALL_LIMIT + 1);

    logic [CW-1:0] cnt_q;

    assign hit = stalled && (cnt_q == CW'(STALL_LIMIT - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!stalled || hit) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    AST_STALL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt_q) < STALL_LIMIT); // R8

endmodule

// File: rtl/txr_engine_fsm.sv
module txr_engine_fsm
    import txr_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int LEN_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              demand,
    input  logic              poll_due,
    input  logic [ADDR_W-1:0] desc_addr,
    input  logic              stall_hit,
    output logic              in_idle,
    output logic              advance,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic [7:0]        tx_data,
    output logic              tx_valid,
    output logic              tx_last,
    input  logic              tx_ready,
    input  logic              mac_status_vld,
    input  logic              mac_one_coll,
    input  logic              mac_multi_coll,
    input  logic              mac_late_coll,
    input  logic              mac_lost_carrier,
    input  logic              mac_retry_fail,
    input  logic [TDR_W-1:0]  mac_tdr,
    output logic              tx_irq
);
    txr_state_e state_q, state_d;

    logic [WORD_W-1:0] stat_q;
    logic [WORD_W-1:0] ladr_q;
    logic [LEN_W-1:0]  len_q;
    logic [LEN_W-1:0]  sent_q;
    logic [WORD_W-1:0] word_q;
    logic [WORD_W-1:0] err_q;
    logic              one_q;
    logic              more_q;

    logic              frame_ok;
    logic              at_last;
    logic              err_any;
    logic [ADDR_W-1:0] buf_addr;
    logic [WORD_W-1:0] stat_out;

    assign frame_ok = stat_q[SB_STP] && stat_q[SB_ENP] && (len_q != '0);
    assign at_last  = (sent_q == len_q - LEN_W'(1));
    assign err_any  = err_q[EB_BUFF] | err_q[EB_UFLO] | err_q[EB_LCOL]
                    | err_q[EB_LCAR] | err_q[EB_RTRY];
    assign buf_addr = ADDR_W'({stat_q[HADR_W-1:0], ladr_q}) + ADDR_W'(sent_q >> 1);
    assign stat_out = {1'b0, err_any, more_q, one_q, stat_q[11:0]};

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:       if (demand || poll_due) state_d = ST_FETCH_STAT;
            ST_FETCH_STAT: if (mem_ack) state_d = mem_rdata[SB_OWN] ? ST_FETCH_ADDR : ST_IDLE;
            ST_FETCH_ADDR: if (mem_ack) state_d = ST_FETCH_CNT;
            ST_FETCH_CNT:  if (mem_ack) state_d = ST_CLEAR_ERR;
            ST_CLEAR_ERR:  if (mem_ack) state_d = frame_ok ? ST_FETCH_DATA : ST_STORE_ERR;
            ST_FETCH_DATA: if (mem_ack) state_d = ST_SEND;
            ST_SEND: begin
                if (tx_ready) begin
                    if (at_last)        state_d = ST_WAIT_MAC;
                    else if (sent_q[0]) state_d = ST_FETCH_DATA;
                    else                state_d = ST_SEND;
                end else if (stall_hit) begin
                    state_d = ST_STORE_ERR;
                end
            end
            ST_WAIT_MAC:   if (mac_status_vld) state_d = ST_STORE_ERR;
            ST_STORE_ERR:  if (mem_ack) state_d = ST_STORE_STAT;
            ST_STORE_STAT: if (mem_ack) state_d = ST_FETCH_STAT;
            default:       state_d = ST_IDLE;
        endcase
    end

    // captured descriptor fields and outcome flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
            ladr_q <= '0;
            len_q  <= '0;
            sent_q <= '0;
            word_q <= '0;
            err_q  <= '0;
            one_q  <= 1'b0;
            more_q <= 1'b0;
        end else begin
            case (state_q)
                ST_FETCH_STAT: if (mem_ack) stat_q <= mem_rdata;
                ST_FETCH_ADDR: if (mem_ack) ladr_q <= mem_rdata;
                ST_FETCH_CNT: begin
                    if (mem_ack) begin
                        len_q  <= LEN_W'(0) - mem_rdata[LEN_W-1:0];
                        sent_q <= '0;
                        err_q  <= '0;
                        one_q  <= 1'b0;
                        more_q <= 1'b0;
                    end
                end
                ST_CLEAR_ERR: if (mem_ack && !frame_ok) err_q[EB_BUFF] <= 1'b1;
                ST_FETCH_DATA: if (mem_ack) word_q <= mem_rdata;
                ST_SEND: begin
                    if (tx_ready) begin
                        sent_q <= sent_q + LEN_W'(1);
                    end else if (stall_hit) begin
                        err_q[EB_UFLO] <= 1'b1;
                    end
                end
                ST_WAIT_MAC: begin
                    if (mac_status_vld) begin
                        err_q[EB_LCOL]    <= mac_late_coll;
                        err_q[EB_LCAR]    <= mac_lost_carrier;
                        err_q[EB_RTRY]    <= mac_retry_fail;
                        err_q[TDR_W-1:0]  <= mac_tdr;
                        one_q             <= mac_one_coll;
                        more_q            <= mac_multi_coll;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        tx_valid  = 1'b0;
        tx_last   = 1'b0;
        tx_data   = sent_q[0] ? word_q[15:8] : word_q[7:0];
        unique case (state_q)
            ST_FETCH_STAT: begin
                mem_req  = 1'b1;
                mem_addr = desc_addr + ADDR_W'(OFF_STAT);
            end
            ST_FETCH_ADDR: begin
                mem_req  = 1'b1;
                mem_addr = desc_addr + ADDR_W'(OFF_LADR);
            end
            ST_FETCH_CNT: begin
                mem_req  = 1'b1;
                mem_addr = desc_addr + ADDR_W'(OFF_CNT);
            end
            ST_CLEAR_ERR: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = desc_addr + ADDR_W'(OFF_ERR);
            end
            ST_FETCH_DATA: begin
                mem_req  = 1'b1;
                mem_addr = buf_addr;
            end
            ST_SEND: begin
                tx_valid = 1'b1;
                tx_last  = at_last;
            end
            ST_STORE_ERR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = desc_addr + ADDR_W'(OFF_ERR);
                mem_wdata = err_q;
            end
            ST_STORE_STAT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = desc_addr + ADDR_W'(OFF_STAT);
                mem_wdata = stat_out;
            end
            default: ;
        endcase
    end

    assign in_idle = (state_q == ST_IDLE);
    assign advance = (state_q == ST_STORE_STAT) && mem_ack;
    assign tx_irq  = advance;

    AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !stall_hit) |=> (tx_valid && $stable(tx_data))); // R11
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R12
    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |=> !tx_irq); // R9
    AST_OWN_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |-> (mem_we && !mem_wdata[SB_OWN])); // R7
    AST_NO_STREAM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        in_idle |-> (!tx_valid && !mem_req)); // R2

endmodule

// File: rtl/tx_ring_engine.sv
module tx_ring_engine
    import txr_pkg::*;
#(
    parameter int ADDR_W      = 24,
    parameter int MAX_LOG2    = 7,
    parameter int LEN_W       = 12,
    parameter int POLL_CYCLES = 1024,
    parameter int STALL_LIMIT = 256
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ADDR_W-1:0]             ring_base,
    input  logic [$clog2(MAX_LOG2+1)-1:0] ring_log2,
    input  logic                          tx_demand,
    output logic                          mem_req,
    output logic                          mem_we,
    output logic [ADDR_W-1:0]             mem_addr,
    output logic [15:0]                   mem_wdata,
    input  logic [15:0]                   mem_rdata,
    input  logic                          mem_ack,
    output logic [7:0]                    tx_data,
    output logic                          tx_valid,
    output logic                          tx_last,
    input  logic                          tx_ready,
    input  logic                          mac_status_vld,
    input  logic                          mac_one_coll,
    input  logic                          mac_multi_coll,
    input  logic                          mac_late_coll,
    input  logic                          mac_lost_carrier,
    input  logic                          mac_retry_fail,
    input  logic [9:0]                    mac_tdr,
    output logic                          tx_irq
);
    logic [ADDR_W-1:0] desc_addr;
    logic              advance;
    logic              in_idle;
    logic              poll_due;
    logic              stall_hit;
    logic              stalled;

    assign stalled = tx_valid && !tx_ready;

    txr_ring_index #(.ADDR_W(ADDR_W), .MAX_LOG2(MAX_LOG2)) u_index (
        .clk       (clk),
        .rst_n     (rst_n),
        .advance   (advance),
        .ring_log2 (ring_log2),
        .ring_base (ring_base),
        .desc_addr (desc_addr)
    );

    txr_poll_timer #(.POLL_CYCLES(POLL_CYCLES)) u_poll (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (in_idle),
        .due   (poll_due)
    );

    txr_stall_watch #(.STALL_LIMIT(STALL_LIMIT)) u_stall (
        .clk     (clk),
        .rst_n   (rst_n),
        .stalled (stalled),
        .hit     (stall_hit)
    );

    txr_engine_fsm #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_fsm (
        .clk              (clk),
        .rst_n            (rst_n),
        .demand           (tx_demand),
        .poll_due         (poll_due),
        .desc_addr        (desc_addr),
        .stall_hit        (stall_hit),
        .in_idle          (in_idle),
        .advance          (advance),
        .mem_req          (mem_req),
        .mem_we           (mem_we),
        .mem_addr         (mem_addr),
        .mem_wdata        (mem_wdata),
        .mem_rdata        (mem_rdata),
        .mem_ack          (mem_ack),
        .tx_data          (tx_data),
        .tx_valid         (tx_valid),
        .tx_last          (tx_last),
        .tx_ready         (tx_ready),
        .mac_status_vld   (mac_status_vld),
        .mac_one_coll     (mac_one_coll),
        .mac_multi_coll   (mac_multi_coll),
        .mac_late_coll    (mac_late_coll),
        .mac_lost_carrier (mac_lost_carrier),
        .mac_retry_fail   (mac_retry_fail),
        .mac_tdr          (mac_tdr),
        .tx_irq           (tx_irq)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        $rose(rst_n) |-> (!tx_valid && !tx_irq && !mem_req)); // R1

endmodule

// File: tb/tx_ring_engine_bench.sv
module tx_ring_engine_bench;
    localparam int ADDR_W = 24;
    localparam int MAX_LOG2 = 7;
    localparam int LEN_W = 12;
    localparam int POLL = 300;
    localparam int STALL = 64;
    localparam int RING = 'h040;
    localparam int BUFB = 'h100;
    localparam logic [7:0] HADR = 8'h5A;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n = 1'b0;
    logic [ADDR_W-1:0] ring_base = ADDR_W'(RING);
    logic [2:0] ring_log2 = 3'd2;
    logic tx_demand = 1'b0;
    logic mem_req, mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic mem_ack = 1'b0;
    logic [7:0] tx_data;
    logic tx_valid, tx_last;
    logic tx_ready = 1'b0;
    logic mac_status_vld = 1'b0;
    logic cfg_one = 0, cfg_more = 0, cfg_late = 0, cfg_lcar = 0, cfg_retry = 0;
    logic [9:0] cfg_tdr = '0;
    logic tx_irq;

    tx_ring_engine #(.ADDR_W(ADDR_W), .MAX_LOG2(MAX_LOG2), .LEN_W(LEN_W),
                     .POLL_CYCLES(POLL), .STALL_LIMIT(STALL)) u_tx_ring_engine (
        .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .ring_log2(ring_log2),
        .tx_demand(tx_demand), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_last(tx_last), .tx_ready(tx_ready),
        .mac_status_vld(mac_status_vld), .mac_one_coll(cfg_one), .mac_multi_coll(cfg_more),
        .mac_late_coll(cfg_late), .mac_lost_carrier(cfg_lcar), .mac_retry_fail(cfg_retry),
        .mac_tdr(cfg_tdr), .tx_irq(tx_irq));

    // memory model with bench write port
    logic [15:0] mem [0:4095];
    logic bw_en = 1'b0;
    int bw_addr = 0;
    logic [15:0] bw_data = '0;
    always_ff @(posedge clk) begin
        if (bw_en) mem[bw_addr[11:0]] <= bw_data;
        if (!rst_n) begin
            mem_ack <= 1'b0;
        end else if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;
            else mem_rdata <= mem[mem_addr[11:0]];
        end else begin
            mem_ack <= 1'b0;
        end
    end

    // stream capture, interrupt count, handshake monitors
    logic [7:0] cap [0:4095];
    logic cap_l [0:4095];
    int cap_n = 0, irq_cnt = 0, hold_viol = 0, req_viol = 0;
    int ready_mode = 1, stall_mark = 0;
    logic pv_valid = 0, pv_ready = 0, pv_req = 0, pv_ack = 0, pv_we = 0;
    logic [7:0] pv_data = '0;
    logic [ADDR_W-1:0] pv_addr = '0;
    always_ff @(posedge clk) begin
        if (tx_valid && tx_ready) begin
            cap[cap_n] <= tx_data;
            cap_l[cap_n] <= tx_last;
            cap_n <= cap_n + 1;
        end
        if (tx_irq) irq_cnt <= irq_cnt + 1;
        if (rst_n && pv_valid && !pv_ready && ready_mode != 2 && !(tx_valid && tx_data == pv_data))
            hold_viol <= hold_viol + 1;
        if (rst_n && pv_req && !pv_ack && !(mem_req && mem_addr == pv_addr && mem_we == pv_we))
            req_viol <= req_viol + 1;
        pv_valid <= tx_valid; pv_ready <= tx_ready; pv_data <= tx_data;
        pv_req <= mem_req; pv_ack <= mem_ack; pv_addr <= mem_addr; pv_we <= mem_we;
    end

    always @(negedge clk) begin
        case (ready_mode)
            0: tx_ready = ($urandom_range(3) != 0);
            1: tx_ready = 1'b1;
            default: tx_ready = (cap_n < stall_mark);
        endcase
    end

    // MAC stub: outcome strobe three cycles after the final byte
    int mac_wait = 0;
    always_ff @(posedge clk) begin
        mac_status_vld <= 1'b0;
        if (tx_valid && tx_ready && tx_last) mac_wait <= 3;
        else if (mac_wait > 1) mac_wait <= mac_wait - 1;
        else if (mac_wait == 1) begin
            mac_wait <= 0;
            mac_status_vld <= 1'b1;
        end
    end

    int checks = 0, errors = 0, exp_idx = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bwrite(input int a, input logic [15:0] d);
        @(negedge clk);
        bw_en = 1'b1; bw_addr = a; bw_data = d;
        @(negedge clk);
        bw_en = 1'b0;
    endtask

    function automatic int dbase(input int idx);
        return RING + 4 * idx;
    endfunction

    function automatic logic [15:0] exp_stat(input logic [11:0] low, input logic [15:0] err,
                                             input logic one, input logic more);
        logic e;
        e = err[15] | err[14] | err[12] | err[11] | err[10];
        return {1'b0, e, more, one, low};
    endfunction

    function automatic logic [15:0] exp_err_mac(input logic late, input logic lcar,
                                                input logic rtry, input logic [9:0] tdr);
        return {3'b000, late, lcar, rtry, tdr};
    endfunction

    task automatic setup_desc(input int idx, input int len, input bit stp, input bit enp, input bit own);
        int bw;
        bw = BUFB + idx * 64;
        for (int w = 0; w < (len + 1) / 2; w++) bwrite(bw + w, 16'($urandom));
        bwrite(dbase(idx) + 0, 16'(bw));
        bwrite(dbase(idx) + 2, 16'(-len));
        bwrite(dbase(idx) + 3, 16'hDEAD);
        bwrite(dbase(idx) + 1, {own, 5'b0, stp, enp, HADR});
    endtask

    task automatic pulse_demand();
        @(negedge clk); tx_demand = 1'b1;
        @(negedge clk); tx_demand = 1'b0;
    endtask

    task automatic wait_irq(input int target, input string req);
        int n;
        n = 0;
        while (irq_cnt < target && n < 8000) begin
            @(negedge clk); n++;
        end
        chk(irq_cnt >= target, req, 32'(irq_cnt), 32'(target));
        repeat (4) @(negedge clk);
    endtask

    task automatic random_mac();
        int k;
        k = $urandom_range(2);
        cfg_one = (k == 1); cfg_more = (k == 2);
        cfg_late = ($urandom_range(3) == 0);
        cfg_lcar = ($urandom_range(3) == 0);
        cfg_retry = ($urandom_range(3) == 0);
        cfg_tdr = 10'($urandom);
    endtask

    // check bytes streamed since c0 against the buffer of slot idx
    task automatic chk_bytes(input int idx, input int c0, input int nb, input string req);
        int bad, bw;
        logic [15:0] w;
        logic [7:0] e;
        bad = 0; bw = BUFB + idx * 64;
        chk(cap_n - c0 == nb, req, 32'(cap_n - c0), 32'(nb));
        for (int i = 0; i < nb; i++) begin
            w = mem[bw + i / 2];
            e = (i % 2) ? w[15:8] : w[7:0];
            if (cap[c0 + i] !== e) bad++;
            if (cap_l[c0 + i] !== (i == nb - 1)) bad++;
        end
        if (nb > 0) chk(bad == 0, req, 32'(bad), 32'd0);
    endtask

    task automatic do_frame(input int len, input bit stp, input bit enp, input bit use_demand);
        int c0, i0, idx, nb;
        logic [15:0] eerr;
        logic one, more;
        idx = exp_idx; c0 = cap_n; i0 = irq_cnt;
        random_mac();
        setup_desc(idx, len, stp, enp, 1'b1);
        if (use_demand) pulse_demand();
        wait_irq(i0 + 1, use_demand ? "R9" : "R3");
        if (stp && enp && len != 0) begin
            nb = len; eerr = exp_err_mac(cfg_late, cfg_lcar, cfg_retry, cfg_tdr);
            one = cfg_one; more = cfg_more;
            chk_bytes(idx, c0, nb, "R4");
            chk(mem[dbase(idx) + 3] == eerr, "R6", 32'(mem[dbase(idx) + 3]), 32'(eerr));
        end else begin
            nb = 0; eerr = 16'h8000; one = 0; more = 0;
            chk_bytes(idx, c0, nb, "R5");
            chk(mem[dbase(idx) + 3] == eerr, "R5", 32'(mem[dbase(idx) + 3]), 32'(eerr));
        end
        chk(mem[dbase(idx) + 1] == exp_stat({3'b0, stp, enp, HADR}, eerr, one, more), "R7",
            32'(mem[dbase(idx) + 1]), 32'(exp_stat({3'b0, stp, enp, HADR}, eerr, one, more)));
        chk(irq_cnt == i0 + 1, "R9", 32'(irq_cnt), 32'(i0 + 1));
        exp_idx = (exp_idx + 1) & 3;
    endtask

    initial begin
        int s, c0, i0, idx, e2;
        logic [15:0] eerr;
        s = $urandom(32'd2024);
        for (int i = 0; i < 4096; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        chk(!tx_valid && !tx_irq && !mem_req, "R1", {29'b0, tx_valid, tx_irq, mem_req}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!tx_valid && !tx_irq && !mem_req, "R1", {29'b0, tx_valid, tx_irq, mem_req}, 32'd0);

        // slot beyond the four-entry ring, owned but must never be touched (R10)
        setup_desc(4, 6, 1'b1, 1'b1, 1'b1);

        // R2: unowned descriptor ignored
        c0 = cap_n; i0 = irq_cnt;
        setup_desc(0, 8, 1'b1, 1'b1, 1'b0);
        pulse_demand();
        repeat (40) @(negedge clk);
        chk(cap_n == c0 && irq_cnt == i0, "R2", 32'(cap_n - c0), 32'd0);
        chk(mem[dbase(0) + 1] == {8'h03, HADR} && mem[dbase(0) + 3] == 16'hDEAD, "R2",
            {mem[dbase(0) + 1], mem[dbase(0) + 3]}, {8'h03, HADR, 16'hDEAD});

        // directed short frames, ready always high
        ready_mode = 1;
        do_frame(1, 1, 1, 1);
        do_frame(2, 1, 1, 1);
        // random frames with random back-pressure
        ready_mode = 0;
        for (int k = 0; k < 6; k++) do_frame($urandom_range(60, 3), 1, 1, 1);
        // R5 rejected descriptors
        do_frame(10, 1, 0, 1);
        do_frame(10, 0, 1, 1);
        do_frame(0, 1, 1, 1);

        // R8: sink stalls after three bytes
        idx = exp_idx; c0 = cap_n; i0 = irq_cnt;
        stall_mark = c0 + 3; ready_mode = 2;
        setup_desc(idx, 10, 1, 1, 1);
        pulse_demand();
        wait_irq(i0 + 1, "R8");
        chk(cap_n - c0 == 3, "R8", 32'(cap_n - c0), 32'd3);
        chk(mem[dbase(idx) + 3] == 16'h4000, "R8", 32'(mem[dbase(idx) + 3]), 32'h4000);
        chk(mem[dbase(idx) + 1] == {8'h43, HADR}, "R8", 32'(mem[dbase(idx) + 1]), {16'h0, 8'h43, HADR});
        exp_idx = (exp_idx + 1) & 3;
        ready_mode = 0;

        // R3: no demand, poll finds the descriptor
        do_frame(12, 1, 1, 0);

        // R10: two owned descriptors, one demand, both released
        idx = exp_idx; e2 = (exp_idx + 1) & 3; c0 = cap_n; i0 = irq_cnt;
        random_mac();
        eerr = exp_err_mac(cfg_late, cfg_lcar, cfg_retry, cfg_tdr);
        setup_desc(e2, 7, 1, 1, 1);
        setup_desc(idx, 5, 1, 1, 1);
        pulse_demand();
        wait_irq(i0 + 2, "R10");
        chk(cap_n - c0 == 12, "R10", 32'(cap_n - c0), 32'd12);
        chk(mem[dbase(idx) + 1][15] == 1'b0 && mem[dbase(e2) + 1][15] == 1'b0, "R10",
            {mem[dbase(idx) + 1], mem[dbase(e2) + 1]}, 32'd0);
        chk(mem[dbase(e2) + 3] == eerr, "R6", 32'(mem[dbase(e2) + 3]), 32'(eerr));
        exp_idx = (exp_idx + 2) & 3;
        chk(mem[dbase(4) + 1] == {8'h83, HADR} && mem[dbase(4) + 3] == 16'hDEAD, "R10",
            {mem[dbase(4) + 1], mem[dbase(4) + 3]}, {8'h83, HADR, 16'hDEAD});

        chk(hold_viol == 0, "R11", 32'(hold_viol), 32'd0);
        chk(req_viol == 0, "R12", 32'(req_viol), 32'd0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog actual=hung expected=completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule